// File: doc/BRIEF.md
# DMA Channel Register Window Bank

This block is the register file of a DMA controller built with either two or eight channels, chosen by a parameter. It decodes a 4 KB byte-addressed space. Each channel owns a 32-byte window that holds its source address, destination address, list pointer, control word and configuration word. A small global area holds the controller configuration, a sync word, status words supplied by a separate interrupt block, clear words sent back to it, and four software request words that read as zero. The top of the space returns eight fixed identification bytes. The first of these bytes tells the two variants apart.

Bus accesses are single-cycle requests. Read data, the error flag and every side-band pulse appear in the cycle after the request is sampled. A write to any channel configuration word, or to the global configuration word, sends a one-cycle kick to the transfer engine so that it rescans its channels. The engine has its own write port. It uses this port to store updated addresses, counts and configuration words back into the channel registers. A bus write to the same register in the same cycle overrides the engine.

Top module: `dmac_regbank`

## Requirements
- R1: After reset every channel register, the global configuration word and the sync word read zero, and bus_rdata_o, bus_err_o, kick_o, tc_clr_o and err_clr_o are low.
- R2: Channel c (c < NUM_CH) owns byte offsets 0x100 + 32*c to 0x100 + 32*c + 0x13. Within the window, +0x00 is source, +0x04 destination, +0x08 list pointer, +0x0C control and +0x10 configuration. A write is stored at the clock edge that samples it. A read returns the word in bus_rdata_o during the following cycle.
- R3: In the channel area, a window offset of 0x14 to 0x1F, or a channel index (offset bits 7:5) of NUM_CH or more, is invalid. A read there returns zero, and either a read or a write raises bus_err_o for one cycle. A write there changes no register.
- R4: A read at 0xFE0 + 4*k returns identification byte k in bits 7:0, with the upper bits zero. Byte 0 is 0x80 when NUM_CH is 8 and 0x81 otherwise. Bytes 1 to 7 are 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. A write in this range is an error.
- R5: Offset 0x030 is the global configuration word and offset 0x034 is the sync word. Both can be read and written.
- R6: Offsets 0x020 to 0x02C (software request words) read zero without error. Writes to them are accepted without error and have no effect.
- R7: kick_o pulses high for exactly the cycle after an accepted write to a channel configuration word or to 0x030. It stays low after any other access.
- R8: Reads of the status words return zero-extended NUM_CH-bit values. Offset 0x000 returns st_mask_tc_i | st_mask_err_i, 0x004 returns st_mask_tc_i, 0x00C returns st_mask_err_i, 0x014 returns st_raw_tc_i, 0x018 returns st_raw_err_i, and 0x01C returns the enabled-channel mask, whose bit c is bit 0 of channel c's configuration word. Writes to these six words are errors.
- R9: A write to 0x008 pulses tc_clr_o, and a write to 0x010 pulses err_clr_o. In both cases clr_mask_o carries bus_wdata_i[NUM_CH-1:0] in the same cycle. Reads of 0x008 and 0x010 are errors.
- R10: Any other offset (0x038 to 0x0FF, 0x200 to 0xFDF) reads zero and raises bus_err_o for one cycle, and a write there changes nothing.
- R11: When eng_we_i is high, the register of channel eng_ch_i selected by eng_reg_i is loaded with eng_wdata_i. The codes are 0 source, 1 destination, 2 list pointer, 3 control and 4 configuration.
- R12: If a bus write and an engine write hit the same register in the same cycle, the bus value is stored. If they hit different registers, both values are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus request valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset (bits 1:0 ignored) |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, cycle after request |
| bus_err_o | output | 1 | Invalid access flag, cycle after request |
| kick_o | output | 1 | Rescan pulse to the engine |
| eng_we_i | input | 1 | Engine write-back strobe |
| eng_ch_i | input | CH_W | Engine target channel |
| eng_reg_i | input | 3 | Engine target register code |
| eng_wdata_i | input | DW | Engine write-back data |
| st_mask_tc_i | input | NUM_CH | Masked terminal-count status |
| st_mask_err_i | input | NUM_CH | Masked error status |
| st_raw_tc_i | input | NUM_CH | Raw terminal-count status |
| st_raw_err_i | input | NUM_CH | Raw error status |
| tc_clr_o | output | 1 | Terminal-count clear pulse |
| err_clr_o | output | 1 | Error clear pulse |
| clr_mask_o | output | NUM_CH | Channels to clear |
| ch_src_o | output | NUM_CH*DW | All source registers, channel 0 in low bits |
| ch_dst_o | output | NUM_CH*DW | All destination registers |
| ch_lli_o | output | NUM_CH*DW | All list pointers |
| ch_ctrl_o | output | NUM_CH*DW | All control words |
| ch_cfg_o | output | NUM_CH*DW | All configuration words |
| glb_cfg_o | output | DW | Global configuration word |
| sync_o | output | DW | Sync word |

## Verification
A wrong decode shows up in the very next cycle. The read returns the wrong word, or bus_err_o goes high when it should stay low or stays low when it should go high. A misrouted write, a lost engine write-back or a wrong collision winner does not appear when it happens. It appears when that register is next read through its window, so the bench follows every write with reads that land on the same registers. Kick and clear pulses that are missing or extra are visible one cycle after the request that should or should not have caused them.

// File: rtl/dmac_rb_pkg.sv
package dmac_rb_pkg;
  localparam int AW   = 12;  // 4 KB register space
  localparam int NREG = 5;   // registers per channel window

  typedef enum logic [3:0] {
    K_BAD, K_CHAN, K_ID, K_ZERO, K_GCFG, K_SYNC,
    K_ST_ALL, K_ST_TC, K_ST_ERR, K_RAW_TC, K_RAW_ERR, K_ENA,
    K_CLR_TC, K_CLR_ERR
  } acc_kind_e;

  function automatic logic [7:0] id_byte(input logic [2:0] k, input logic wide);
    case (k)
      3'd0:    return wide ? 8'h80 : 8'h81;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h0A;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dmac_rb_decode.sv
module dmac_rb_decode
  import dmac_rb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  output acc_kind_e     kind_o,
  output logic [2:0]    ch_idx_o,
  output logic [2:0]    reg_idx_o
);
  localparam logic [3:0] NCH4 = 4'(NUM_CH);
  localparam logic [3:0] NREG4 = 4'(NREG);

  always_comb begin
    kind_o    = K_BAD;
    ch_idx_o  = addr_i[7:5];
    reg_idx_o = addr_i[4:2];
    if (addr_i[11:8] == 4'h1) begin
      if (({1'b0, addr_i[7:5]} < NCH4) && ({1'b0, addr_i[4:2]} < NREG4))
        kind_o = K_CHAN;
    end else if (addr_i[11:5] == 7'h7F) begin
      kind_o = wr_i ? K_BAD : K_ID;
    end else if (addr_i[11:8] == 4'h0) begin
      case (addr_i[7:2])
        6'd0:  kind_o = wr_i ? K_BAD : K_ST_ALL;
        6'd1:  kind_o = wr_i ? K_BAD : K_ST_TC;
        6'd2:  kind_o = wr_i ? K_CLR_TC : K_BAD;
        6'd3:  kind_o = wr_i ? K_BAD : K_ST_ERR;
        6'd4:  kind_o = wr_i ? K_CLR_ERR : K_BAD;
        6'd5:  kind_o = wr_i ? K_BAD : K_RAW_TC;
        6'd6:  kind_o = wr_i ? K_BAD : K_RAW_ERR;
        6'd7:  kind_o = wr_i ? K_BAD : K_ENA;
        6'd8, 6'd9, 6'd10, 6'd11: kind_o = K_ZERO;
        6'd12: kind_o = K_GCFG;
        6'd13: kind_o = K_SYNC;
        default: kind_o = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/dmac_rb_chan.sv
module dmac_rb_chan
  import dmac_rb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [2:0]    bus_reg_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          eng_we_i,
  input  logic [2:0]    eng_reg_i,
  input  logic [DW-1:0] eng_wdata_i,
  input  logic [2:0]    rd_reg_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] lli_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cfg_o
);
  localparam logic [2:0] NREG3 = 3'(NREG);

  logic [NREG-1:0][DW-1:0] q, d;
  logic                    en;

  always_comb begin
    d = q;
    if (eng_we_i && eng_reg_i < NREG3) d[eng_reg_i] = eng_wdata_i;
    if (bus_we_i && bus_reg_i < NREG3) d[bus_reg_i] = bus_wdata_i; // bus wins
  end

  assign en = bus_we_i | eng_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (en)  q <= d;
  end

  assign rd_data_o = (rd_reg_i < NREG3) ? q[rd_reg_i] : '0;
  assign src_o  = q[0];
  assign dst_o  = q[1];
  assign lli_o  = q[2];
  assign ctrl_o = q[3];
  assign cfg_o  = q[4];

  a_r12_bus_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && eng_we_i && bus_reg_i == eng_reg_i && bus_reg_i < NREG3)
    |=> q[$past(bus_reg_i)] == $past(bus_wdata_i));

  a_r11_eng_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_we_i && eng_reg_i < NREG3 && !(bus_we_i && bus_reg_i == eng_reg_i))
    |=> q[$past(eng_reg_i)] == $past(eng_wdata_i));
endmodule

// File: rtl/dmac_rb_rdmux.sv
module dmac_rb_rdmux #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          rd_i,
  input  logic          bad_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  logic [DW-1:0] rdata_d;
  logic          err_d;

  always_comb begin
    err_d   = acc_i & bad_i;
    rdata_d = (acc_i && rd_i && !bad_i) ? word_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end

  a_r10_err_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  a_r10_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(acc_i));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_rb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  output logic                 bus_err_o,
  output logic                 kick_o,
  input  logic                 eng_we_i,
  input  logic [CH_W-1:0]      eng_ch_i,
  input  logic [2:0]           eng_reg_i,
  input  logic [DW-1:0]        eng_wdata_i,
  input  logic [NUM_CH-1:0]    st_mask_tc_i,
  input  logic [NUM_CH-1:0]    st_mask_err_i,
  input  logic [NUM_CH-1:0]    st_raw_tc_i,
  input  logic [NUM_CH-1:0]    st_raw_err_i,
  output logic                 tc_clr_o,
  output logic                 err_clr_o,
  output logic [NUM_CH-1:0]    clr_mask_o,
  output logic [NUM_CH*DW-1:0] ch_src_o,
  output logic [NUM_CH*DW-1:0] ch_dst_o,
  output logic [NUM_CH*DW-1:0] ch_lli_o,
  output logic [NUM_CH*DW-1:0] ch_ctrl_o,
  output logic [NUM_CH*DW-1:0] ch_cfg_o,
  output logic [DW-1:0]        glb_cfg_o,
  output logic [DW-1:0]        sync_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  acc_kind_e  kind;
  logic [2:0] ch_idx, reg_idx;
  logic       bad, wr_ok;

  dmac_rb_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i    (bus_addr_i),
    .wr_i      (bus_wr_i),
    .kind_o    (kind),
    .ch_idx_o  (ch_idx),
    .reg_idx_o (reg_idx)
  );

  assign bad   = (kind == K_BAD);
  assign wr_ok = bus_sel_i & bus_wr_i & ~bad;

  logic [DW-1:0]     chan_rd [NUM_CH];
  logic [NUM_CH-1:0] ena_mask;
  logic [CH_W-1:0]   ch_sel;

  assign ch_sel = ch_idx[CH_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DW-1:0] cfg_w;
    dmac_rb_chan #(.DW(DW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .bus_we_i    (wr_ok && kind == K_CHAN && ch_idx == 3'(i)),
      .bus_reg_i   (reg_idx),
      .bus_wdata_i (bus_wdata_i),
      .eng_we_i    (eng_we_i && eng_ch_i == CH_W'(i)),
      .eng_reg_i   (eng_reg_i),
      .eng_wdata_i (eng_wdata_i),
      .rd_reg_i    (reg_idx),
      .rd_data_o   (chan_rd[i]),
      .src_o       (ch_src_o[i*DW +: DW]),
      .dst_o       (ch_dst_o[i*DW +: DW]),
      .lli_o       (ch_lli_o[i*DW +: DW]),
      .ctrl_o      (ch_ctrl_o[i*DW +: DW]),
      .cfg_o       (cfg_w)
    );
    assign ch_cfg_o[i*DW +: DW] = cfg_w;
    assign ena_mask[i] = cfg_w[0];
  end

  // global words: next-state and register processes
  logic [DW-1:0] gcfg_q, gcfg_d, sync_q, sync_d;
  logic          gcfg_en, sync_en;

  always_comb begin
    gcfg_en = wr_ok && kind == K_GCFG;
    sync_en = wr_ok && kind == K_SYNC;
    gcfg_d  = bus_wdata_i;
    sync_d  = bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q <= '0;
      sync_q <= '0;
    end else begin
      if (gcfg_en) gcfg_q <= gcfg_d;
      if (sync_en) sync_q <= sync_d;
    end
  end

  assign glb_cfg_o = gcfg_q;
  assign sync_o    = sync_q;

  // read word selection
  logic [DW-1:0] rd_word;
  always_comb begin
    case (kind)
      K_CHAN:    rd_word = chan_rd[ch_sel];
      K_ID:      rd_word = DW'(id_byte(bus_addr_i[4:2], NUM_CH == 8));
      K_GCFG:    rd_word = gcfg_q;
      K_SYNC:    rd_word = sync_q;
      K_ST_ALL:  rd_word = DW'(st_mask_tc_i | st_mask_err_i);
      K_ST_TC:   rd_word = DW'(st_mask_tc_i);
      K_ST_ERR:  rd_word = DW'(st_mask_err_i);
      K_RAW_TC:  rd_word = DW'(st_raw_tc_i);
      K_RAW_ERR: rd_word = DW'(st_raw_err_i);
      K_ENA:     rd_word = DW'(ena_mask);
      default:   rd_word = '0;
    endcase
  end

  dmac_rb_rdmux #(.DW(DW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .acc_i   (bus_sel_i),
    .rd_i    (~bus_wr_i),
    .bad_i   (bad),
    .word_i  (rd_word),
    .rdata_o (bus_rdata_o),
    .err_o   (bus_err_o)
  );

  // side-band pulses
  logic              kick_d, tcc_d, errc_d;
  logic [NUM_CH-1:0] mask_d;

  always_comb begin
    kick_d = wr_ok && (kind == K_GCFG || (kind == K_CHAN && reg_idx == 3'd4));
    tcc_d  = wr_ok && kind == K_CLR_TC;
    errc_d = wr_ok && kind == K_CLR_ERR;
    mask_d = (tcc_d || errc_d) ? bus_wdata_i[NUM_CH-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      kick_o     <= 1'b0;
      tc_clr_o   <= 1'b0;
      err_clr_o  <= 1'b0;
      clr_mask_o <= '0;
    end else begin
      kick_o     <= kick_d;
      tc_clr_o   <= tcc_d;
      err_clr_o  <= errc_d;
      clr_mask_o <= mask_d;
    end
  end

  a_r7_kick_after_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    kick_o |-> $past(bus_sel_i && bus_wr_i));
  a_r9_one_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({tc_clr_o, err_clr_o}));
  a_r9_clr_after_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tc_clr_o || err_clr_o) |-> $past(bus_sel_i && bus_wr_i));
  a_r5_sync_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(bus_sel_i && bus_wr_i) |-> $stable(sync_o));
endmodule

// File: tb/tb_dmac_regbank.sv
`timescale 1ns/1ps
module tb_dmac_regbank;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic            sel, wr, ewe;
  logic [11:0]     addr;
  logic [DW-1:0]   wdata, ewd;
  logic [2:0]      ech, ereg;
  logic [NCH-1:0]  smtc, smerr, srtc, srerr;
  logic [DW-1:0]   rdata;
  logic            err, kick, tcc, errc;
  logic [NCH-1:0]  cmask;
  logic [NCH*DW-1:0] o_src, o_dst, o_lli, o_ctrl, o_cfg;
  logic [DW-1:0]   o_gcfg, o_sync;

  dmac_regbank #(.NUM_CH(NCH), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_err_o(err), .kick_o(kick), .eng_we_i(ewe), .eng_ch_i(ech),
    .eng_reg_i(ereg), .eng_wdata_i(ewd), .st_mask_tc_i(smtc),
    .st_mask_err_i(smerr), .st_raw_tc_i(srtc), .st_raw_err_i(srerr),
    .tc_clr_o(tcc), .err_clr_o(errc), .clr_mask_o(cmask),
    .ch_src_o(o_src), .ch_dst_o(o_dst), .ch_lli_o(o_lli),
    .ch_ctrl_o(o_ctrl), .ch_cfg_o(o_cfg), .glb_cfg_o(o_gcfg), .sync_o(o_sync)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] m_ch [NCH][5];
  logic [DW-1:0] m_gcfg, m_sync;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] idb(input int k);
    case (k)
      0: return (NCH == 8) ? 8'h80 : 8'h81;
      1: return 8'h10;  2: return 8'h04;  3: return 8'h0A;
      4: return 8'h0D;  5: return 8'hF0;  6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  // expected outcome of one access, from the requirements
  task automatic expect_acc(input logic [11:0] a, input bit w, output bit bad,
                            output logic [DW-1:0] d, output bit kk,
                            output int clr, output string tag);
    int ch, off, wd;
    logic [NCH-1:0] ena;
    bad = 0; d = '0; kk = 0; clr = 0; tag = "R10";
    for (int i = 0; i < NCH; i++) ena[i] = m_ch[i][4][0];
    if (a >= 12'h100 && a < 12'h200) begin
      ch = int'(a[7:5]); off = int'(a[4:0]);
      if (ch >= NCH || off >= 'h14) begin bad = 1; tag = "R3"; end
      else begin
        tag = "R2"; d = m_ch[ch][off/4];
        kk = w && (off/4 == 4);
        if (kk) tag = "R7";
      end
    end else if (a >= 12'hFE0) begin
      tag = "R4";
      if (w) bad = 1; else d = DW'(idb(int'(a[4:2])));
    end else if (a < 12'h100) begin
      wd = int'(a[7:2]);
      case (wd)
        0: begin tag = "R8"; if (w) bad = 1; else d = DW'(smtc | smerr); end
        1: begin tag = "R8"; if (w) bad = 1; else d = DW'(smtc); end
        3: begin tag = "R8"; if (w) bad = 1; else d = DW'(smerr); end
        5: begin tag = "R8"; if (w) bad = 1; else d = DW'(srtc); end
        6: begin tag = "R8"; if (w) bad = 1; else d = DW'(srerr); end
        7: begin tag = "R8"; if (w) bad = 1; else d = DW'(ena); end
        2: begin tag = "R9"; if (!w) bad = 1; else clr = 1; end
        4: begin tag = "R9"; if (!w) bad = 1; else clr = 2; end
        8, 9, 10, 11: tag = "R6";
        12: begin tag = "R5"; d = m_gcfg; kk = w; if (w) tag = "R7"; end
        13: begin tag = "R5"; d = m_sync; end
        default: bad = 1;
      endcase
    end else bad = 1;
  endtask

  task automatic step(input bit s, input bit w, input logic [11:0] a,
                      input logic [DW-1:0] d, input bit e_we, input logic [2:0] e_ch,
                      input logic [2:0] e_reg, input logic [DW-1:0] e_d,
                      input string force_tag);
    bit xbad, xk; logic [DW-1:0] xd; int xclr; string tag;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d;
    ewe = e_we; ech = e_ch; ereg = e_reg; ewd = e_d;
    expect_acc(a, w, xbad, xd, xk, xclr, tag);
    if (force_tag != "") tag = force_tag;
    if (!s) begin xbad = 0; xk = 0; xclr = 0; end
    @(posedge clk); #1;
    chk(err == xbad, {tag, " err"}, DW'(err), DW'(xbad));
    chk(rdata == ((s && !w && !xbad) ? xd : '0), {tag, " rdata"}, rdata,
        (s && !w && !xbad) ? xd : '0);
    chk(kick == (xk && !xbad), {"R7 kick ", tag}, DW'(kick), DW'(xk && !xbad));
    chk(tcc == (xclr == 1) && errc == (xclr == 2), "R9 clear pulse",
        DW'({tcc, errc}), DW'({xclr == 1, xclr == 2}));
    if (xclr != 0) chk(cmask == d[NCH-1:0], "R9 mask", DW'(cmask), DW'(d[NCH-1:0]));
    if (e_we && int'(e_reg) < 5) m_ch[e_ch][e_reg] = e_d;
    if (s && w && !xbad) begin
      if (a >= 12'h100 && a < 12'h200) m_ch[a[7:5]][a[4:2]] = d;
      else if (a == 12'h030) m_gcfg = d;
      else if (a == 12'h034) m_sync = d;
    end
    sel = 0; ewe = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string t);
    step(1, 0, a, '0, 0, '0, '0, '0, t);
  endtask
  task automatic wrt(input logic [11:0] a, input logic [DW-1:0] d, input string t);
    step(1, 1, a, d, 0, '0, '0, '0, t);
  endtask
  function automatic logic [11:0] cha(input int c, input int r);
    return 12'(32'h100 + c * 32 + r * 4);
  endfunction

  initial begin
    #(100000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    sel = 0; wr = 0; addr = '0; wdata = '0; ewe = 0; ech = '0; ereg = '0; ewd = '0;
    smtc = '0; smerr = '0; srtc = '0; srerr = '0;
    for (int i = 0; i < NCH; i++) for (int r = 0; r < 5; r++) m_ch[i][r] = '0;
    m_gcfg = '0; m_sync = '0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(rdata == 0 && err == 0 && kick == 0 && tcc == 0 && errc == 0, "R1 reset outputs",
        rdata, '0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    // R1: registers read zero after reset
    rd(cha(0, 0), "R1"); rd(cha(7, 4), "R1"); rd(12'h030, "R1"); rd(12'h034, "R1");
    // R2 window layout
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) wrt(cha(c, r), $urandom, "R2");
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) rd(cha(c, r), "R2");
    // R3 window offsets past configuration
    wrt(12'h114, 32'hDEAD, "R3"); wrt(12'h1FC, 32'hBEEF, "R3");
    rd(12'h118, "R3"); rd(cha(0, 3), "R3"); rd(cha(7, 4), "R3");
    // R4 identification
    for (int k = 0; k < 8; k++) rd(12'(32'hFE0 + k * 4), "R4");
    wrt(12'hFE0, 32'h1, "R4");
    // R5 global words
    wrt(12'h030, 32'h0000_0001, "R5"); wrt(12'h034, 32'hA5A5_5A5A, "R5");
    rd(12'h030, "R5"); rd(12'h034, "R5");
    // R6 software request words
    for (int k = 8; k < 12; k++) wrt(12'(k * 4), 32'hFFFF_FFFF, "R6");
    for (int k = 8; k < 12; k++) rd(12'(k * 4), "R6");
    // R8 status
    smtc = 8'h5A; smerr = 8'h81; srtc = 8'hF0; srerr = 8'h0F;
    rd(12'h000, "R8"); rd(12'h004, "R8"); rd(12'h00C, "R8");
    rd(12'h014, "R8"); rd(12'h018, "R8"); rd(12'h01C, "R8");
    wrt(12'h000, 32'h1, "R8");
    // R9 clears
    wrt(12'h008, 32'h0000_00C3, "R9"); wrt(12'h010, 32'h0000_003C, "R9");
    rd(12'h008, "R9"); rd(12'h010, "R9");
    // R10 unmapped
    rd(12'h038, "R10"); rd(12'h0FC, "R10"); rd(12'h200, "R10"); rd(12'hFDC, "R10");
    wrt(12'h800, 32'h1234, "R10");
    rd(12'h034, "R10");
    // R11 engine write-back, R12 collisions
    step(0, 0, '0, '0, 1, 3'd2, 3'd3, 32'h0000_0777, "R11");
    rd(cha(2, 3), "R11");
    step(1, 1, cha(4, 1), 32'h1111_1111, 1, 3'd4, 3'd1, 32'h2222_2222, "R12");
    rd(cha(4, 1), "R12");
    step(1, 1, cha(5, 0), 32'h3333_3333, 1, 3'd5, 3'd2, 32'h4444_4444, "R12");
    rd(cha(5, 0), "R12"); rd(cha(5, 2), "R12");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a; int r; bit w, e;
      r = int'($urandom % 8);
      case (r)
        0, 1, 2, 3: a = 12'h100 | 12'($urandom % 256) & 12'hFFC;
        4: a = 12'($urandom % 16) << 2;
        5: a = 12'hFE0 | (12'($urandom % 8) << 2);
        6: a = 12'($urandom % 4096) & 12'hFFC;
        default: a = ($urandom % 2) ? 12'h030 : cha(int'($urandom % NCH), 4);
      endcase
      w = ($urandom % 2) == 1;
      e = ($urandom % 3) == 0;
      smtc = NCH'($urandom); smerr = NCH'($urandom);
      srtc = NCH'($urandom); srerr = NCH'($urandom);
      step(1, w, a, $urandom, e, 3'($urandom % NCH), 3'($urandom % 5), $urandom, "");
    end
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) rd(cha(c, r), "R12");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule